// File: doc/BRIEF.md
# Nibble-Wide Receive Framing Controller

This block sits right behind a 4-bit media-independent receive interface of a 10/100 Ethernet MAC. It watches the receive data valid line and the incoming nibbles. It tracks the preamble, finds the start-of-frame delimiter, and then alternates between the low and high nibble of each payload byte. A frame that the receiver must not take is parked in a drop state until data valid falls. That covers a frame that arrives while the MAC is sending, one with a malformed preamble, one whose delimiter comes too soon after the previous frame, and one that runs past the maximum length. Downstream logic gets the one-hot state flags, a start-of-frame strobe, an end-of-frame strobe, and a byte strobe with the assembled byte.

The state register is one-hot. An all-zero detector on that register forces the drop state, so losing the state bit cannot halt the receiver. A gap counter counts idle nibble times between frames, and a byte counter enforces the length limit. Both counters live in a small datapath, which the control drives through a struct of strobes.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is held and after its release, stateFlags equals 6'b000001 (Idle), and sofStrobe, eofStrobe and byteValid are 0. The flag bit positions are Idle=0, Drop=1, Preamble=2, Delim=3, Low=4 and High=5.
- R2: At most one bit of stateFlags is set in any cycle.
- R3: In Idle, rxDv=1 together with txBusy=1 moves the block to Drop, even when the nibble is 4'h5.
- R4: In Idle, rxDv=1 with nibble 4'h5 and txBusy=0 enters Preamble. Preamble on 4'h5 enters Delim, and Delim stays in Delim on 4'h5. Any other nibble while rxDv=1 goes to Drop: a nibble other than 4'h5 in Idle or Preamble, or a nibble other than 4'h5 or 4'hD in Delim.
- R5: In Delim, rxDv=1 with nibble 4'hD enters Low if at least IfgNibbles cycles with rxDv=0 have passed since the last non-Idle state ended. In that case sofStrobe is 1 in the same cycle that the Low flag first shows. Otherwise the block goes to Drop and sofStrobe stays 0.
- R6: With rxDv=1, Low moves to High and High moves to Low. The cycle after a High nibble is taken, byteValid is 1 and rxByte holds {high nibble, low nibble}. byteValid is 0 in all other cycles.
- R7: Once MaxBytes bytes of a frame have been taken, a further nibble in Low with rxDv=1 sends the block to Drop. A frame of exactly MaxBytes bytes ends normally.
- R8: Drop holds while rxDv=1 and returns to Idle when rxDv=0. Neither Drop nor its exit raises sofStrobe, eofStrobe or byteValid.
- R9: rxDv=0 in Low or High returns to Idle with eofStrobe=1 in that cycle. rxDv=0 in Preamble or Delim returns to Idle with eofStrobe=0.
- R10: If the state register ever holds all zeros, the next state is Drop regardless of the inputs.
- R11: After reset the gap condition counts as already met, so a frame that starts right after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxDv | input | 1 | Receive data valid |
| rxNib | input | 4 | Receive nibble |
| txBusy | input | 1 | The MAC is transmitting |
| stateFlags | output | 6 | One-hot state: Idle, Drop, Preamble, Delim, Low, High (bit 0 to 5) |
| sofStrobe | output | 1 | Delimiter accepted; first cycle of Low |
| eofStrobe | output | 1 | Frame ended cleanly from Low or High |
| byteValid | output | 1 | rxByte holds a new byte |
| rxByte | output | 8 | Assembled byte, high nibble in bits 7:4 |

## Verification
The length limit and the end of a frame can meet in one cycle. When the byte count reaches MaxBytes, the block is back in Low. If rxDv falls at that moment, the frame must close with eofStrobe rather than fall into Drop. If one more nibble arrives instead, the frame must drop. The bench sweeps the frame length from zero to two bytes over a small limit and judges each length arithmetically: it expects the byte strobes, the byte values, and either a clean end or a drop at byte MaxBytes. A second sweep moves the idle gap across the IfgNibbles threshold and expects acceptance exactly when the gap reaches it.

// File: rtl/mii_rx_framer_pkg.sv
package mii_rx_framer_pkg;

  localparam int NumStates = 6;

  localparam int StIdle  = 0;
  localparam int StDrop  = 1;
  localparam int StPre   = 2;
  localparam int StDelim = 3;
  localparam int StLow   = 4;
  localparam int StHigh  = 5;

  localparam logic [3:0] NibPre   = 4'h5;
  localparam logic [3:0] NibDelim = 4'hD;

  typedef struct packed {
    logic sofHit;
    logic eofHit;
    logic captureLo;
    logic captureByte;
    logic gapClear;
  } rxCtl_t;

endpackage

// File: rtl/mii_rx_framer_ctrl.sv
module mii_rx_framer_ctrl
  import mii_rx_framer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxDv,
  input  logic [3:0]           rxNib,
  input  logic                 txBusy,
  input  logic                 gapOk,
  input  logic                 maxReached,
  output logic [NumStates-1:0] stateQ,
  output rxCtl_t               ctl
);

  logic [NumStates-1:0] nextState;
  logic idle, drop, pre, delim, low, high;
  logic anyActive, noneActive, isPre, isDelim;

  assign idle  = stateQ[StIdle];
  assign drop  = stateQ[StDrop];
  assign pre   = stateQ[StPre];
  assign delim = stateQ[StDelim];
  assign low   = stateQ[StLow];
  assign high  = stateQ[StHigh];

  // Lost-bit guard: an empty state register steers into Drop.
  assign anyActive  = |stateQ;
  assign noneActive = ~anyActive;

  assign isPre   = (rxNib == NibPre);
  assign isDelim = (rxNib == NibDelim);

  always_comb begin
    nextState = '0;
    nextState[StIdle]  = ~rxDv & anyActive;
    nextState[StDrop]  = noneActive |
                         (rxDv & (drop |
                                  (idle & txBusy) |
                                  (idle & ~isPre) |
                                  (pre & ~isPre) |
                                  (delim & isDelim & ~gapOk) |
                                  (delim & ~isPre & ~isDelim) |
                                  (low & maxReached)));
    nextState[StPre]   = rxDv & idle & ~txBusy & isPre;
    nextState[StDelim] = rxDv & (pre | delim) & isPre;
    nextState[StLow]   = rxDv & ((delim & isDelim & gapOk) | high);
    nextState[StHigh]  = rxDv & low & ~maxReached;
  end

  always_comb begin
    ctl             = '0;
    ctl.sofHit      = rxDv & delim & isDelim & gapOk;
    ctl.captureLo   = rxDv & low & ~maxReached;
    ctl.captureByte = rxDv & high;
    ctl.eofHit      = ~rxDv & (low | high);
    ctl.gapClear    = ~rxDv & anyActive & ~idle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= NumStates'(1) << StIdle;
    end else begin
      stateQ <= nextState;
    end
  end

endmodule

// File: rtl/mii_rx_framer_dp.sv
module mii_rx_framer_dp
  import mii_rx_framer_pkg::*;
#(
  parameter int IfgNibbles = 24,
  parameter int MaxBytes   = 1518
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxDv,
  input  logic [3:0] rxNib,
  input  rxCtl_t     ctl,
  output logic       gapOk,
  output logic       maxReached,
  output logic       sofStrobe,
  output logic       eofStrobe,
  output logic       byteValid,
  output logic [7:0] rxByte
);

  localparam int GapW  = $clog2(IfgNibbles + 1);
  localparam int CntW  = $clog2(MaxBytes + 1);
  localparam logic [GapW-1:0] GapTop = GapW'(IfgNibbles);
  localparam logic [CntW-1:0] CntTop = CntW'(MaxBytes);

  logic [GapW-1:0] gapCnt;
  logic [CntW-1:0] byteCnt;
  logic [3:0]      loNibQ;

  assign gapOk      = (gapCnt == GapTop);
  assign maxReached = (byteCnt >= CntTop);

  // Idle-gap counter: restarts at 1 on the nibble that closes activity,
  // counts further idle nibbles and saturates at the threshold.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= GapTop;
    end else if (ctl.gapClear) begin
      gapCnt <= GapW'(1);
    end else if (!rxDv && gapCnt != GapTop) begin
      gapCnt <= gapCnt + GapW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (ctl.sofHit) begin
      byteCnt <= '0;
    end else if (ctl.captureByte && byteCnt != CntTop) begin
      byteCnt <= byteCnt + CntW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loNibQ    <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      sofStrobe <= 1'b0;
      eofStrobe <= 1'b0;
    end else begin
      if (ctl.captureLo) begin
        loNibQ <= rxNib;
      end
      if (ctl.captureByte) begin
        rxByte <= {rxNib, loNibQ};
      end
      byteValid <= ctl.captureByte;
      sofStrobe <= ctl.sofHit;
      eofStrobe <= ctl.eofHit;
    end
  end

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_framer_pkg::*;
#(
  parameter int IfgNibbles = 24,
  parameter int MaxBytes   = 1518
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxDv,
  input  logic [3:0]           rxNib,
  input  logic                 txBusy,
  output logic [NumStates-1:0] stateFlags,
  output logic                 sofStrobe,
  output logic                 eofStrobe,
  output logic                 byteValid,
  output logic [7:0]           rxByte
);

  rxCtl_t ctl;
  logic   gapOk;
  logic   maxReached;

  mii_rx_framer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxDv       (rxDv),
    .rxNib      (rxNib),
    .txBusy     (txBusy),
    .gapOk      (gapOk),
    .maxReached (maxReached),
    .stateQ     (stateFlags),
    .ctl        (ctl)
  );

  mii_rx_framer_dp #(
    .IfgNibbles (IfgNibbles),
    .MaxBytes   (MaxBytes)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxDv       (rxDv),
    .rxNib      (rxNib),
    .ctl        (ctl),
    .gapOk      (gapOk),
    .maxReached (maxReached),
    .sofStrobe  (sofStrobe),
    .eofStrobe  (eofStrobe),
    .byteValid  (byteValid),
    .rxByte     (rxByte)
  );

endmodule

// File: rtl/mii_rx_framer_chk.sv
module mii_rx_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxDv,
  input logic       txBusy,
  input logic [5:0] stateFlags,
  input logic       sofStrobe,
  input logic       eofStrobe,
  input logic       byteValid,
  input logic       maxReached
);

  p_at_most_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stateFlags));

  p_recover_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateFlags == 6'b000000) |=> (stateFlags == 6'b000010));

  p_tx_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateFlags[0] && rxDv && txBusy) |=> stateFlags[1]);

  p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateFlags[1] && rxDv) |=> (stateFlags[1] && !sofStrobe && !byteValid));

  p_sof_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |-> (stateFlags[4] && $past(stateFlags[3])));

  p_byte_after_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (stateFlags[4] && $past(stateFlags[5]) && $past(rxDv)));

  p_max_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateFlags[4] && rxDv && maxReached) |=> stateFlags[1]);

  p_eof_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    eofStrobe |-> (stateFlags[0] && ($past(stateFlags[4]) || $past(stateFlags[5]))));

endmodule

bind mii_rx_framer mii_rx_framer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxDv       (rxDv),
  .txBusy     (txBusy),
  .stateFlags (stateFlags),
  .sofStrobe  (sofStrobe),
  .eofStrobe  (eofStrobe),
  .byteValid  (byteValid),
  .maxReached (maxReached)
);

// File: tb/mii_rx_framer_tb.sv
`timescale 1ns/1ps
module mii_rx_framer_tb;

  localparam int Ifg = 24;
  localparam int Max = 6;

  localparam logic [5:0] SIdle  = 6'b000001;
  localparam logic [5:0] SDrop  = 6'b000010;
  localparam logic [5:0] SPre   = 6'b000100;
  localparam logic [5:0] SDelim = 6'b001000;
  localparam logic [5:0] SLow   = 6'b010000;
  localparam logic [5:0] SHigh  = 6'b100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxDv = 1'b0;
  logic [3:0] rxNib = 4'h0;
  logic       txBusy = 1'b0;
  logic [5:0] stateFlags;
  logic       sofStrobe, eofStrobe, byteValid;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mii_rx_framer #(.IfgNibbles(Ifg), .MaxBytes(Max)) u_dut (
    .clk(clk), .rstN(rstN), .rxDv(rxDv), .rxNib(rxNib), .txBusy(txBusy),
    .stateFlags(stateFlags), .sofStrobe(sofStrobe), .eofStrobe(eofStrobe),
    .byteValid(byteValid), .rxByte(rxByte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic dv, input logic [3:0] nib, input logic tx);
    @(negedge clk);
    rxDv = dv; rxNib = nib; txBusy = tx;
    @(posedge clk);
    #2;
  endtask

  task automatic idleFor(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0);
  endtask

  task automatic preamble();
    step(1'b1, 4'h5, 1'b0); check("R4 preamble entry", stateFlags, SPre);
    step(1'b1, 4'h5, 1'b0); check("R4 delim entry", stateFlags, SDelim);
    step(1'b1, 4'h5, 1'b0); check("R4 delim hold", stateFlags, SDelim);
  endtask

  task automatic frame(input int nb);
    bit dropped = 0;
    idleFor(30);
    preamble();
    step(1'b1, 4'hD, 1'b0);
    check("R5 accept", stateFlags, SLow);
    check("R5 sof", sofStrobe, 1);
    for (int i = 0; i < nb && !dropped; i++) begin
      logic [7:0] b = 8'((i * 37 + nb * 11 + 5) & 255);
      step(1'b1, b[3:0], 1'b0);
      if (i == Max) begin
        check("R7 over length drop", stateFlags, SDrop);
        check("R7 no byte on drop", byteValid, 0);
        dropped = 1;
      end else begin
        check("R6 low to high", stateFlags, SHigh);
        check("R6 no byte on low", byteValid, 0);
        check("R5 sof single", sofStrobe, 0);
        step(1'b1, b[7:4], 1'b0);
        check("R6 high to low", stateFlags, SLow);
        check("R6 byte valid", byteValid, 1);
        check("R6 byte value", rxByte, b);
      end
    end
    if (dropped) begin
      step(1'b1, 4'hD, 1'b0);
      check("R8 drop hold", stateFlags, SDrop);
      step(1'b0, 4'h0, 1'b0);
      check("R8 drop exit", stateFlags, SIdle);
      check("R8 no eof", eofStrobe, 0);
    end else begin
      step(1'b0, 4'h0, 1'b0);
      check("R9 data end idle", stateFlags, SIdle);
      check("R9 eof", eofStrobe, 1);
      check("R7 limit frame ends", byteValid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", stateFlags, SIdle);
    check("R1 reset strobes", {sofStrobe, eofStrobe, byteValid}, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 after release", stateFlags, SIdle);

    // R11: frame right after reset with no idle gap is accepted.
    preamble();
    step(1'b1, 4'hD, 1'b0);
    check("R11 post-reset accept", stateFlags, SLow);
    check("R11 sof", sofStrobe, 1);
    step(1'b0, 4'h0, 1'b0);
    check("R9 empty frame eof", eofStrobe, 1);

    // R3: transmit guard wins over a preamble nibble.
    idleFor(30);
    step(1'b1, 4'h5, 1'b1);
    check("R3 tx busy drop", stateFlags, SDrop);
    step(1'b1, 4'h5, 1'b0);
    step(1'b1, 4'hD, 1'b0);
    check("R8 drop holds on delim", stateFlags, SDrop);
    check("R8 no sof", sofStrobe, 0);
    step(1'b0, 4'h0, 1'b0);
    check("R8 back to idle", stateFlags, SIdle);

    // R4: malformed nibbles in each early state.
    idleFor(30);
    step(1'b1, 4'h3, 1'b0);
    check("R4 bad nibble in idle", stateFlags, SDrop);
    idleFor(30);
    step(1'b1, 4'h5, 1'b0);
    step(1'b1, 4'h7, 1'b0);
    check("R4 bad nibble in preamble", stateFlags, SDrop);
    idleFor(30);
    step(1'b1, 4'h5, 1'b0);
    step(1'b1, 4'h5, 1'b0);
    step(1'b1, 4'hA, 1'b0);
    check("R4 bad nibble in delim", stateFlags, SDrop);

    // R9: truncated preamble ends without eof.
    idleFor(30);
    step(1'b1, 4'h5, 1'b0);
    step(1'b0, 4'h0, 1'b0);
    check("R9 preamble abort idle", stateFlags, SIdle);
    check("R9 preamble abort no eof", eofStrobe, 0);
    idleFor(30);
    preamble();
    step(1'b0, 4'h0, 1'b0);
    check("R9 delim abort idle", stateFlags, SIdle);
    check("R9 delim abort no eof", eofStrobe, 0);

    // R6/R7: frame length sweep across the limit.
    for (int nb = 0; nb <= Max + 2; nb++) frame(nb);

    // R5: idle gap sweep across the threshold.
    for (int g = 1; g <= Ifg + 6; g++) begin
      step(1'b1, 4'h3, 1'b0);
      check("R4 sweep setup drop", stateFlags, SDrop);
      idleFor(g);
      preamble();
      step(1'b1, 4'hD, 1'b0);
      check("R5 gap decision", stateFlags, (g >= Ifg) ? SLow : SDrop);
      check("R5 gap sof", sofStrobe, (g >= Ifg) ? 1 : 0);
      step(1'b0, 4'h0, 1'b0);
      check("R9 gap sweep idle", stateFlags, SIdle);
    end

    // R10: lost state bit recovers into Drop, even with a preamble nibble.
    idleFor(30);
    @(negedge clk);
    rxDv = 1'b1; rxNib = 4'h5; txBusy = 1'b0;
    force u_dut.u_ctrl.stateQ = 6'b000000;
    #1;
    release u_dut.u_ctrl.stateQ;
    @(posedge clk); #2;
    check("R10 recovery to drop", stateFlags, SDrop);
    step(1'b0, 4'h0, 1'b0);
    check("R10 recovery then idle", stateFlags, SIdle);
    @(negedge clk);
    rxDv = 1'b0;
    force u_dut.u_ctrl.stateQ = 6'b000000;
    #1;
    release u_dut.u_ctrl.stateQ;
    @(posedge clk); #2;
    check("R10 recovery idle input", stateFlags, SDrop);
    step(1'b0, 4'h0, 1'b0);
    check("R10 second exit", stateFlags, SIdle);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule